// File: doc/BRIEF.md
# Sequential Vector Register Execution Unit

This unit runs whole-register vector instructions on a small bank of vector registers. An instruction names two source registers and a destination, and a single shared arithmetic lane steps through the element positions, one per clock, from element 0 upward. Each result is written back in the cycle it is computed. The second operand is either the matching element of another register (vector-vector form) or one scalar value that the unit captures when it accepts the instruction (vector-scalar form). Integer add, subtract and multiply are provided, plus a copy operation. All arithmetic wraps at the element width.

A controller issues an instruction with a valid/ready handshake. It watches `busy` and waits for the one-cycle `done` pulse, then issues the next instruction. While the unit is idle, a host port writes any element of any register and reads any element back combinationally. This port is used to preload operands and to collect results. While an instruction runs, the host port is shut off.

Top module: `vec_seq_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `issue_ready` is 1.
- R2: An instruction is accepted only on a clock edge where `issue_valid` and `issue_ready` are both 1. A request presented while `busy` is 1 is dropped completely: no register changes, and it does not start later.
- R3: `busy` rises in the cycle after acceptance and stays high for exactly NUM_ELEMS (64) cycles. `done` is high for exactly one cycle, the first cycle after `busy` falls, and `issue_ready` is high again in that same cycle.
- R4: With `issue_op` = 0 (add) and `issue_form` = 0 (vector-vector), destination element i becomes A[i] + B[i] modulo 2^64.
- R5: With `issue_op` = 1 (subtract), destination element i becomes A[i] - B[i] modulo 2^64.
- R6: With `issue_op` = 2 (multiply), destination element i becomes the low 64 bits of A[i] * B[i].
- R7: With `issue_form` = 1 (vector-scalar), the second operand of every element is the value of `scalar_in` sampled at the accepting edge. Later changes of `scalar_in` have no effect.
- R8: A destination that equals one or both sources gives the same result as separate registers, because element i is read before it is written.
- R9: While idle, `host_we` = 1 writes `host_wdata` to element `host_idx` of register `host_reg` at the clock edge. `host_rdata` shows that element combinationally.
- R10: While `busy` is 1, host writes are ignored and `host_rdata` reads 0.
- R11: With `issue_op` = 3 (copy), destination element i becomes A[i]. B and the scalar are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | Instruction request |
| issue_ready | output | 1 | Unit idle, a request will be accepted |
| issue_op | input | 2 | 0 add, 1 sub, 2 mul, 3 copy |
| issue_form | input | 1 | 0 vector-vector, 1 vector-scalar |
| issue_srca | input | 3 | Source A register |
| issue_srcb | input | 3 | Source B register |
| issue_dst | input | 3 | Destination register |
| scalar_in | input | 64 | Scalar operand, captured on acceptance |
| busy | output | 1 | Instruction executing |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host element write strobe |
| host_reg | input | 3 | Host register select |
| host_idx | input | 6 | Host element select |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, 0 while busy |

## Verification
The assertions check the sequencing rules on every cycle:
- an accepted request always starts a run, and every run starts from a request;
- the element counter advances by one per busy cycle;
- the last element always produces a single `done` pulse;
- a host write attempted during a run leaves the addressed element untouched.

The arithmetic results can only be shown by the bench's scenarios, which compare each destination register against a reference model. This covers wrap-around, low-half multiply, scalar capture while `scalar_in` keeps changing, in-place aliasing and the copy operation. The bench scenarios also show that a request presented during a run is dropped and never starts afterwards.

// File: rtl/vsu_pkg.sv
package vsu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_COPY = 2'd3
  } vop_e;

  typedef enum logic {
    FORM_VV = 1'b0,
    FORM_VS = 1'b1
  } vform_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vstate_e;

endpackage

// File: rtl/vsu_rst_sync.sv
module vsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/vsu_seq.sv
module vsu_seq
  import vsu_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int NUM_ELEMS = 64,
  parameter int DATA_W    = 64,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int IDX_W    = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [1:0]        issue_op,
  input  logic              issue_form,
  input  logic [REG_W-1:0]  issue_srca,
  input  logic [REG_W-1:0]  issue_srcb,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [DATA_W-1:0] scalar_in,
  output logic              issue_ready,
  output logic              busy,
  output logic              done,
  output logic              elem_we,
  output logic [IDX_W-1:0]  cur_idx,
  output vop_e              cur_op,
  output vform_e            cur_form,
  output logic [REG_W-1:0]  cur_srca,
  output logic [REG_W-1:0]  cur_srcb,
  output logic [REG_W-1:0]  cur_dst,
  output logic [DATA_W-1:0] cur_scalar
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEMS - 1);

  vstate_e           state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              done_q, done_d;
  logic              accept;
  logic              last;

  vop_e              op_q;
  vform_e            form_q;
  logic [REG_W-1:0]  srca_q, srcb_q, dst_q;
  logic [DATA_W-1:0] scalar_q;

  assign accept = (state_q == ST_IDLE) && issue_valid;
  assign last   = (idx_q == LAST_IDX);

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          idx_d   = '0;
        end
      end
      ST_RUN: begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  // instruction latch, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_ADD;
      form_q   <= FORM_VV;
      srca_q   <= '0;
      srcb_q   <= '0;
      dst_q    <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      op_q     <= vop_e'(issue_op);
      form_q   <= vform_e'(issue_form);
      srca_q   <= issue_srca;
      srcb_q   <= issue_srcb;
      dst_q    <= issue_dst;
      scalar_q <= scalar_in;
    end
  end

  assign issue_ready = (state_q == ST_IDLE);
  assign busy        = (state_q == ST_RUN);
  assign done        = done_q;
  assign elem_we     = busy;
  assign cur_idx     = idx_q;
  assign cur_op      = op_q;
  assign cur_form    = form_q;
  assign cur_srca    = srca_q;
  assign cur_srcb    = srcb_q;
  assign cur_dst     = dst_q;
  assign cur_scalar  = scalar_q;

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> busy);

  assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(issue_valid));

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx_q == $past(idx_q) + IDX_W'(1)));

  assert_last_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> (done && !busy));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/vsu_lane.sv
module vsu_lane
  import vsu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  vop_e              op,
  input  vform_e            form,
  input  logic [DATA_W-1:0] a_elem,
  input  logic [DATA_W-1:0] b_elem,
  input  logic [DATA_W-1:0] scalar,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] opnd_b;

  assign opnd_b = (form == FORM_VS) ? scalar : b_elem;

  always_comb begin
    unique case (op)
      OP_ADD:  result = a_elem + opnd_b;
      OP_SUB:  result = a_elem - opnd_b;
      OP_MUL:  result = a_elem * opnd_b;
      OP_COPY: result = a_elem;
      default: result = a_elem;
    endcase
  end

endmodule

// File: rtl/vsu_regfile.sv
module vsu_regfile #(
  parameter int NUM_REGS  = 8,
  parameter int NUM_ELEMS = 64,
  parameter int DATA_W    = 64,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int IDX_W    = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [REG_W-1:0]  rd_a_reg,
  input  logic [REG_W-1:0]  rd_b_reg,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              exec_we,
  input  logic [REG_W-1:0]  exec_reg,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              host_we,
  input  logic [REG_W-1:0]  host_reg,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);

  logic [DATA_W-1:0] mem [NUM_REGS][NUM_ELEMS];

  logic              wr_en;
  logic [REG_W-1:0]  wr_reg;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  // single write port: execution owns it while running, host otherwise
  always_comb begin
    if (exec_we) begin
      wr_en   = 1'b1;
      wr_reg  = exec_reg;
      wr_idx  = exec_idx;
      wr_data = exec_data;
    end else begin
      wr_en   = host_we;
      wr_reg  = host_reg;
      wr_idx  = host_idx;
      wr_data = host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_reg][wr_idx] <= wr_data;
  end

  assign rd_a_data  = mem[rd_a_reg][exec_idx];
  assign rd_b_data  = mem[rd_b_reg][exec_idx];
  assign host_rdata = exec_we ? '0 : mem[host_reg][host_idx];

  assert_host_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_we && host_we && !((host_reg == exec_reg) && (host_idx == exec_idx)))
    |=> (mem[$past(host_reg)][$past(host_idx)] === $past(mem[host_reg][host_idx])));

endmodule

// File: rtl/vec_seq_unit.sv
module vec_seq_unit
  import vsu_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int NUM_ELEMS = 64,
  parameter int DATA_W    = 64,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int IDX_W    = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [1:0]        issue_op,
  input  logic              issue_form,
  input  logic [REG_W-1:0]  issue_srca,
  input  logic [REG_W-1:0]  issue_srcb,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [DATA_W-1:0] scalar_in,
  output logic              busy,
  output logic              done,
  input  logic              host_we,
  input  logic [REG_W-1:0]  host_reg,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);

  logic              rst_sync_n;
  logic              elem_we;
  logic [IDX_W-1:0]  cur_idx;
  vop_e              cur_op;
  vform_e            cur_form;
  logic [REG_W-1:0]  cur_srca, cur_srcb, cur_dst;
  logic [DATA_W-1:0] cur_scalar;
  logic [DATA_W-1:0] a_elem, b_elem, lane_res;

  vsu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vsu_seq #(
    .NUM_REGS  (NUM_REGS),
    .NUM_ELEMS (NUM_ELEMS),
    .DATA_W    (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .issue_form  (issue_form),
    .issue_srca  (issue_srca),
    .issue_srcb  (issue_srcb),
    .issue_dst   (issue_dst),
    .scalar_in   (scalar_in),
    .issue_ready (issue_ready),
    .busy        (busy),
    .done        (done),
    .elem_we     (elem_we),
    .cur_idx     (cur_idx),
    .cur_op      (cur_op),
    .cur_form    (cur_form),
    .cur_srca    (cur_srca),
    .cur_srcb    (cur_srcb),
    .cur_dst     (cur_dst),
    .cur_scalar  (cur_scalar)
  );

  vsu_regfile #(
    .NUM_REGS  (NUM_REGS),
    .NUM_ELEMS (NUM_ELEMS),
    .DATA_W    (DATA_W)
  ) u_rf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .exec_idx   (cur_idx),
    .rd_a_reg   (cur_srca),
    .rd_b_reg   (cur_srcb),
    .rd_a_data  (a_elem),
    .rd_b_data  (b_elem),
    .exec_we    (elem_we),
    .exec_reg   (cur_dst),
    .exec_data  (lane_res),
    .host_we    (host_we),
    .host_reg   (host_reg),
    .host_idx   (host_idx),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  vsu_lane #(
    .DATA_W (DATA_W)
  ) u_lane (
    .op     (cur_op),
    .form   (cur_form),
    .a_elem (a_elem),
    .b_elem (b_elem),
    .scalar (cur_scalar),
    .result (lane_res)
  );

endmodule

// File: tb/test_vec_seq_unit.sv
module test_vec_seq_unit;

  logic        clk;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [1:0]  issue_op;
  logic        issue_form;
  logic [2:0]  issue_srca, issue_srcb, issue_dst;
  logic [63:0] scalar_in;
  logic        busy, done;
  logic        host_we;
  logic [2:0]  host_reg;
  logic [5:0]  host_idx;
  logic [63:0] host_wdata;
  logic [63:0] host_rdata;

  int total = 0;
  int bad   = 0;

  logic [63:0] ref_rf [8][64];

  vec_seq_unit i_vec_seq_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_op    (issue_op),
    .issue_form  (issue_form),
    .issue_srca  (issue_srca),
    .issue_srcb  (issue_srcb),
    .issue_dst   (issue_dst),
    .scalar_in   (scalar_in),
    .busy        (busy),
    .done        (done),
    .host_we     (host_we),
    .host_reg    (host_reg),
    .host_idx    (host_idx),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int r, input int i);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + 1)) ^ 64'(i << 3);
  endfunction

  task automatic host_write(input int r, input int i, input logic [63:0] v);
    @(negedge clk);
    host_we = 1'b1; host_reg = 3'(r); host_idx = 6'(i); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    ref_rf[r][i] = v;
  endtask

  // compares a whole register with the model, one check
  task automatic cmp_reg(input int r, input string tag);
    int mism = 0;
    logic [63:0] fa = '0, fe = '0;
    for (int i = 0; i < 64; i++) begin
      host_reg = 3'(r); host_idx = 6'(i);
      #1;
      if (host_rdata !== ref_rf[r][i]) begin
        if (mism == 0) begin fa = host_rdata; fe = ref_rf[r][i]; end
        mism++;
      end
    end
    chk(mism == 0, tag, fa, fe);
  endtask

  task automatic run_instr(input logic [1:0] op, input bit form, input int a, input int b,
                           input int d, input logic [63:0] sc, input bit disturb,
                           input string tag);
    logic [63:0] exp [64];
    logic [63:0] ob;
    int cnt = 0;
    for (int i = 0; i < 64; i++) begin
      ob = form ? sc : ref_rf[b][i];
      case (op)
        2'd0: exp[i] = ref_rf[a][i] + ob;
        2'd1: exp[i] = ref_rf[a][i] - ob;
        2'd2: exp[i] = ref_rf[a][i] * ob;
        default: exp[i] = ref_rf[a][i];
      endcase
    end
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; issue_form = form;
    issue_srca = 3'(a); issue_srcb = 3'(b); issue_dst = 3'(d); scalar_in = sc;
    @(negedge clk);
    issue_valid = 1'b0;
    scalar_in = ~sc;
    while (busy && cnt < 200) begin
      cnt++;
      scalar_in = scalar_in + 64'h1111_0000_0000_0003;
      if (disturb && cnt == 10) begin
        issue_valid = 1'b1; issue_op = 2'd3; issue_form = 1'b0;
        issue_srca = 3'd0; issue_srcb = 3'd0; issue_dst = 3'd6;
        host_we = 1'b1; host_reg = 3'd7; host_idx = 6'd5; host_wdata = 64'hDEAD_BEEF_0BAD_F00D;
        #1;
        chk(host_rdata == 64'h0, "R10 read while busy", host_rdata, 64'h0);
      end
      @(negedge clk);
      issue_valid = 1'b0;
      host_we = 1'b0;
    end
    chk(cnt == 64, {"R3 busy length ", tag}, 64'(cnt), 64'd64);
    chk(done === 1'b1 && issue_ready === 1'b1, {"R3 done after run ", tag},
        {62'd0, done, issue_ready}, 64'd3);
    @(negedge clk);
    chk(done === 1'b0, {"R3 done single pulse ", tag}, 64'(done), 64'd0);
    for (int i = 0; i < 64; i++) ref_rf[d][i] = exp[i];
    cmp_reg(d, tag);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0 && issue_ready === 1'b1, "R1 reset state",
        {61'd0, busy, done, issue_ready}, 64'd1);
  endtask

  task automatic t_host_fill;
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) host_write(r, i, pat(r, i));
    host_write(0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    host_write(1, 0, 64'd2);
    host_write(0, 1, 64'd5);
    host_write(1, 1, 64'd0);
    for (int r = 0; r < 8; r++) cmp_reg(r, "R9 host readback");
  endtask

  task automatic t_add_vv;
    run_instr(2'd0, 1'b0, 0, 1, 2, 64'd0, 1'b0, "R4 add vv");
    host_reg = 3'd2; host_idx = 6'd0; #1;
    chk(host_rdata == 64'd1, "R4 add wraps", host_rdata, 64'd1);
  endtask

  task automatic t_sub_vv;
    run_instr(2'd1, 1'b0, 1, 0, 3, 64'd0, 1'b0, "R5 sub vv");
    host_reg = 3'd3; host_idx = 6'd1; #1;
    chk(host_rdata == 64'hFFFF_FFFF_FFFF_FFFB, "R5 sub wraps", host_rdata, 64'hFFFF_FFFF_FFFF_FFFB);
  endtask

  task automatic t_mul;
    run_instr(2'd2, 1'b0, 0, 1, 6, 64'd0, 1'b0, "R6 mul vv low half");
    run_instr(2'd2, 1'b1, 4, 0, 5, 64'h0000_0001_0000_0003, 1'b0, "R7 mul vs scalar captured");
    run_instr(2'd0, 1'b1, 3, 0, 7, 64'h8000_0000_0000_0001, 1'b0, "R7 add vs scalar captured");
  endtask

  task automatic t_alias;
    run_instr(2'd0, 1'b0, 2, 2, 2, 64'd0, 1'b0, "R8 dst equals both sources");
    run_instr(2'd1, 1'b1, 3, 0, 3, 64'd12345, 1'b0, "R8 dst equals source vs");
  endtask

  task automatic t_copy;
    run_instr(2'd3, 1'b1, 5, 1, 4, 64'hFFFF, 1'b0, "R11 copy");
  endtask

  task automatic t_busy_ignore;
    run_instr(2'd0, 1'b0, 0, 1, 4, 64'd0, 1'b1, "R2 run with request during busy");
    cmp_reg(6, "R2 dropped request left dst unchanged");
    cmp_reg(7, "R10 host write during busy ignored");
    @(negedge clk);
    chk(busy === 1'b0, "R2 dropped request never starts", 64'(busy), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; issue_valid = 1'b0; issue_op = '0; issue_form = 1'b0;
    issue_srca = '0; issue_srcb = '0; issue_dst = '0; scalar_in = '0;
    host_we = 1'b0; host_reg = '0; host_idx = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_host_fill;
    t_add_vv;
    t_sub_vv;
    t_mul;
    t_copy;
    t_alias;
    t_busy_ignore;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule